// File: doc/BRIEF.md
# VCOM Kickback Measurement Controller

This block holds the 9-bit panel common-voltage (VCOM) setting and runs an automatic kickback measurement. The code is 10 mV per LSB, running from 0 V at code 0 down to -5.11 V at code 511. Code 0x07D therefore stands for -1.25 V, and the block comes out of reset with that code. A small register-style write port sets the code, starts a measurement and clears interrupt flags.

During a measurement the block asks an external converter for readings over a valid/data handshake. It takes 1, 2, 4 or 8 readings and sums them. The sum is shifted right by log2 of the reading count, and the result becomes the new VCOM code. A completion flag is then raised.

A request can commit the current code to non-volatile storage as the power-up default. Such commits are limited to 100 over the life of the part. An out-of-range indication from the analog side shuts the driver down and sets a fault flag.

Top module: `vcom_cal_ctrl`

## Requirements
- R1: After reset, `vcom_code_o` is 0x07D, `busy_o`, `smp_req_o`, `hiz_o`, `nvm_wr_o` and all three flags are 0, `nvm_used_o` is 0 and `drv_en_o` is 1.
- R2: A write to address 0 loads `wr_data_i[8:0]` into `vcom_code_o` on the next edge when the block is idle. While a measurement runs, such a write is ignored.
- R3: A write to address 1 with bit 0 (acquire) set starts a measurement when the block is idle and no fault is present. `busy_o` and `smp_req_o` are high from the next cycle. Bits [2:1] give the reading count: 00 = 1, 01 = 2, 10 = 4, 11 = 8.
- R4: Each accepted reading (`smp_valid_i` high while busy) is added to a sum. On the edge that accepts the last reading, `vcom_code_o` becomes the sum shifted right by log2(count), and `busy_o` falls.
- R5: The done flag (`irq_done_o`) is set on the completion edge and stays set until a write to address 2 has bit 0 set. If setting and clearing fall on the same edge, the flag stays set.
- R6: An acquire request while busy is ignored. The running measurement keeps its original reading count.
- R7: `range_fault_i` high sets `irq_fault_o` on the next edge. It aborts a running measurement without raising the done flag. While the fault flag is set, `drv_en_o` is low and acquire requests are ignored. Address 2 bit 1 clears the flag, but a fault present on the same edge keeps it set.
- R8: A write to address 1 with bit 4 set asks for a non-volatile commit. While `nvm_used_o` < 100, `nvm_wr_o` pulses for one cycle on the next edge, `nvm_data_o` carries the code, and `nvm_used_o` increments. Once 100 commits are used, the request is refused: there is no pulse and `irq_nvm_err_o` is set. Address 2 bit 2 clears that flag.
- R9: Every write to address 1 loads bit 3 into `hiz_o`, which puts the output stage in high impedance for measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 code, 1 control, 2 flag clear |
| wr_data_i | input | 9 | Write data |
| smp_valid_i | input | 1 | Converter reading valid |
| smp_data_i | input | 9 | Converter reading as a VCOM code |
| smp_req_o | output | 1 | Readings wanted |
| range_fault_i | input | 1 | VCOM outside operating range |
| vcom_code_o | output | 9 | Current VCOM code |
| hiz_o | output | 1 | Output stage high impedance |
| drv_en_o | output | 1 | VCOM driver enable |
| busy_o | output | 1 | Measurement in progress |
| irq_done_o | output | 1 | Measurement complete flag |
| irq_fault_o | output | 1 | Range fault flag |
| irq_nvm_err_o | output | 1 | Commit refused flag |
| nvm_wr_o | output | 1 | Non-volatile write pulse |
| nvm_data_o | output | 9 | Code to store |
| nvm_used_o | output | 7 | Commits used |

## Verification
Several pairs of functions can land on the same edge, and the bench forces each pair together. It drives a flag-clear write in the cycle that delivers the last reading, so completion and done-clear meet. It holds `range_fault_i` high while writing the fault-clear bit, so fault set and fault clear meet. It issues an acquire or a code write in the middle of a measurement, so the new request meets the running one. The bench judges each case at the next falling edge: a set must win over a clear, and the running measurement must keep its count and take the result into the code.

// File: rtl/vcom_pkg.sv
package vcom_pkg;
  localparam logic [1:0] ADDR_CODE = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_CLR  = 2'd2;
  localparam int CTL_ACQ = 0;
  localparam int CTL_AVG = 1;  // two bits
  localparam int CTL_HIZ = 3;
  localparam int CTL_NVM = 4;
  localparam int FLG_DONE  = 0;
  localparam int FLG_FAULT = 1;
  localparam int FLG_NVM   = 2;
  localparam int NFLG      = 3;
endpackage

// File: rtl/vcom_avg.sv
module vcom_avg #(
  parameter int CODE_W = 9,
  parameter int AVG_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AVG_W-1:0]  avg_i,
  input  logic              abort_i,
  input  logic              smp_valid_i,
  input  logic [CODE_W-1:0] smp_data_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic [CODE_W-1:0] res_o
);
  localparam int MAX_SH = (1 << AVG_W) - 1;
  localparam int SUM_W  = CODE_W + MAX_SH;
  localparam int CNT_W  = (MAX_SH > 0) ? MAX_SH : 1;

  logic              busy_q;
  logic [AVG_W-1:0]  sh_q;
  logic [CNT_W-1:0]  cnt_q, last_idx;
  logic [SUM_W-1:0]  acc_q, acc_nxt;
  logic              take;

  assign last_idx = CNT_W'((1 << sh_q) - 1);
  assign take     = busy_q & smp_valid_i & ~abort_i;
  assign acc_nxt  = acc_q + SUM_W'(smp_data_i);
  assign fin_o    = take & (cnt_q == last_idx);
  assign res_o    = acc_nxt[sh_q +: CODE_W];
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      sh_q   <= avg_i;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else if (take) begin
      acc_q <= acc_nxt;
      cnt_q <= cnt_q + 1'b1;
      if (fin_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vcom_nvm_budget.sv
module vcom_nvm_budget #(
  parameter int CODE_W  = 9,
  parameter int NVM_MAX = 100,
  localparam int CNT_W  = $clog2(NVM_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              wr_o,
  output logic [CODE_W-1:0] data_o,
  output logic [CNT_W-1:0]  used_o,
  output logic              refuse_o
);
  logic avail;
  assign avail    = used_o < CNT_W'(NVM_MAX);
  assign refuse_o = req_i & ~avail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o   <= 1'b0;
      data_o <= '0;
      used_o <= '0;
    end else begin
      wr_o <= req_i & avail;
      if (req_i && avail) begin
        data_o <= code_i;
        used_o <= used_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vcom_irq_flags.sv
module vcom_irq_flags #(
  parameter int NF = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] q_o
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q_o[g] <= 1'b0;
      else if (set_i[g])   q_o[g] <= 1'b1;  // set wins
      else if (clr_i[g])   q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/vcom_cal_ctrl.sv
module vcom_cal_ctrl
  import vcom_pkg::*;
#(
  parameter int CODE_W          = 9,
  parameter int AVG_W           = 2,
  parameter int NVM_MAX         = 100,
  parameter logic [8:0] RST_CODE = 9'h07D,
  localparam int CNT_W          = $clog2(NVM_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [CODE_W-1:0] wr_data_i,
  input  logic              smp_valid_i,
  input  logic [CODE_W-1:0] smp_data_i,
  output logic              smp_req_o,
  input  logic              range_fault_i,
  output logic [CODE_W-1:0] vcom_code_o,
  output logic              hiz_o,
  output logic              drv_en_o,
  output logic              busy_o,
  output logic              irq_done_o,
  output logic              irq_fault_o,
  output logic              irq_nvm_err_o,
  output logic              nvm_wr_o,
  output logic [CODE_W-1:0] nvm_data_o,
  output logic [CNT_W-1:0]  nvm_used_o
);
  logic wr_code, wr_ctrl, wr_clr, start, fin, nvm_refuse;
  logic [CODE_W-1:0] res;
  logic [NFLG-1:0]   flg_set, flg_clr, flg_q;

  assign wr_code = wr_en_i & (wr_addr_i == ADDR_CODE);
  assign wr_ctrl = wr_en_i & (wr_addr_i == ADDR_CTRL);
  assign wr_clr  = wr_en_i & (wr_addr_i == ADDR_CLR);
  assign start   = wr_ctrl & wr_data_i[CTL_ACQ] & ~flg_q[FLG_FAULT] & ~range_fault_i;

  vcom_avg #(.CODE_W(CODE_W), .AVG_W(AVG_W)) i_avg (
    .clk_i, .rst_ni,
    .start_i     (start),
    .avg_i       (wr_data_i[CTL_AVG +: AVG_W]),
    .abort_i     (range_fault_i),
    .smp_valid_i,
    .smp_data_i,
    .busy_o,
    .fin_o       (fin),
    .res_o       (res)
  );

  vcom_nvm_budget #(.CODE_W(CODE_W), .NVM_MAX(NVM_MAX)) i_nvm (
    .clk_i, .rst_ni,
    .req_i    (wr_ctrl & wr_data_i[CTL_NVM]),
    .code_i   (vcom_code_o),
    .wr_o     (nvm_wr_o),
    .data_o   (nvm_data_o),
    .used_o   (nvm_used_o),
    .refuse_o (nvm_refuse)
  );

  always_comb begin
    flg_set            = '0;
    flg_set[FLG_DONE]  = fin;
    flg_set[FLG_FAULT] = range_fault_i;
    flg_set[FLG_NVM]   = nvm_refuse;
    flg_clr            = wr_clr ? wr_data_i[NFLG-1:0] : '0;
  end

  vcom_irq_flags #(.NF(NFLG)) i_flags (
    .clk_i, .rst_ni,
    .set_i (flg_set),
    .clr_i (flg_clr),
    .q_o   (flg_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vcom_code_o <= CODE_W'(RST_CODE);
      hiz_o       <= 1'b0;
    end else begin
      if (fin)                      vcom_code_o <= res;
      else if (wr_code && !busy_o)  vcom_code_o <= wr_data_i;
      if (wr_ctrl)                  hiz_o <= wr_data_i[CTL_HIZ];
    end
  end

  assign smp_req_o     = busy_o;
  assign irq_done_o    = flg_q[FLG_DONE];
  assign irq_fault_o   = flg_q[FLG_FAULT];
  assign irq_nvm_err_o = flg_q[FLG_NVM];
  assign drv_en_o      = ~flg_q[FLG_FAULT];
endmodule

// File: rtl/vcom_cal_ctrl_chk.sv
module vcom_cal_ctrl_chk #(
  parameter int CODE_W  = 9,
  parameter int NVM_MAX = 100,
  localparam int CNT_W  = $clog2(NVM_MAX + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [CODE_W-1:0] wr_data_i,
  input logic              smp_valid_i,
  input logic              range_fault_i,
  input logic [CODE_W-1:0] vcom_code_o,
  input logic              hiz_o,
  input logic              drv_en_o,
  input logic              busy_o,
  input logic              irq_done_o,
  input logic              irq_fault_o,
  input logic              nvm_wr_o,
  input logic [CNT_W-1:0]  nvm_used_o
);
  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd1 && wr_data_i[0] && !busy_o && !irq_fault_o && !range_fault_i)
      |=> busy_o);

  p_code_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !smp_valid_i) |=> $stable(vcom_code_o));

  p_done_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_done_o && !(wr_en_i && wr_addr_i == 2'd2 && wr_data_i[0])) |=> irq_done_o);

  p_fault_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_fault_i |=> (irq_fault_o && !drv_en_o && !busy_o && !irq_done_o ||
                       irq_fault_o && !drv_en_o && !busy_o && $past(irq_done_o)));

  p_budget_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nvm_wr_o |-> (nvm_used_o != '0 && nvm_used_o <= CNT_W'(NVM_MAX)));

  p_hiz_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd1) |=> (hiz_o == $past(wr_data_i[3])));
endmodule

bind vcom_cal_ctrl vcom_cal_ctrl_chk #(.CODE_W(CODE_W), .NVM_MAX(NVM_MAX)) i_chk (.*);

// File: tb/test_vcom_cal_ctrl.sv
module test_vcom_cal_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [8:0] wr_data_i = '0;
  logic       smp_valid_i = 1'b0;
  logic [8:0] smp_data_i = '0;
  logic       range_fault_i = 1'b0;
  logic       smp_req_o, hiz_o, drv_en_o, busy_o;
  logic       irq_done_o, irq_fault_o, irq_nvm_err_o, nvm_wr_o;
  logic [8:0] vcom_code_o, nvm_data_o;
  logic [6:0] nvm_used_o;

  int compared = 0;
  int mismatched = 0;
  int exp_code = 'h07D;
  int seed_dummy;

  always #5 clk_i = ~clk_i;

  vcom_cal_ctrl i_vcom_cal_ctrl (.*);

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [8:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [8:0] ctl(input bit acq, input int mode, input bit hiz, input bit nvm);
    return {4'b0, nvm, hiz, mode[1:0], acq};
  endfunction

  function automatic int avg_of(input int sum, input int mode);
    return sum >> mode;
  endfunction

  // full measurement; returns expected result
  task automatic acquire(input int mode, input string tag);
    int sum = 0;
    wr(2'd1, ctl(1, mode, 1, 0));
    chk({tag, " R3 busy"}, busy_o, 1);
    chk({tag, " R3 smp_req"}, smp_req_o, 1);
    chk({tag, " R9 hiz"}, hiz_o, 1);
    for (int i = 0; i < (1 << mode); i++) begin
      @(negedge clk_i);
      if (i > 0) chk({tag, " R4 busy mid"}, busy_o, 1);
      smp_valid_i = 1'b1;
      smp_data_i  = 9'($urandom_range(0, 511));
      sum += smp_data_i;
    end
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    exp_code = avg_of(sum, mode);
    chk({tag, " R4 code"}, vcom_code_o, exp_code);
    chk({tag, " R4 busy low"}, busy_o, 0);
    chk({tag, " R5 done"}, irq_done_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 code", vcom_code_o, 'h07D);
    chk("R1 busy", busy_o, 0);
    chk("R1 smp_req", smp_req_o, 0);
    chk("R1 hiz", hiz_o, 0);
    chk("R1 drv_en", drv_en_o, 1);
    chk("R1 flags", {irq_done_o, irq_fault_o, irq_nvm_err_o}, 0);
    chk("R1 nvm", {nvm_wr_o, nvm_used_o}, 0);

    wr(2'd0, 9'd300); exp_code = 300;
    chk("R2 code write", vcom_code_o, 300);

    // directed: each averaging mode
    for (int m = 0; m < 4; m++) begin
      acquire(m, "dir");
      wr(2'd2, 9'b001);
      chk("R5 done cleared", irq_done_o, 0);
    end

    // R9 hiz clear
    wr(2'd1, ctl(0, 0, 0, 0));
    chk("R9 hiz low", hiz_o, 0);

    // R2/R6: code write and acquire while busy
    begin
      int sum = 0;
      wr(2'd1, ctl(1, 2, 0, 0));
      wr(2'd0, 9'd7);
      chk("R2 write ignored busy", vcom_code_o, exp_code);
      wr(2'd1, ctl(1, 0, 0, 0));
      for (int i = 0; i < 4; i++) begin
        @(negedge clk_i);
        if (i == 2) chk("R6 count kept", busy_o, 1);
        smp_valid_i = 1'b1; smp_data_i = 9'(100 + i * 50); sum += 100 + i * 50;
      end
      @(negedge clk_i); smp_valid_i = 1'b0;
      exp_code = sum >> 2;
      chk("R6 result", vcom_code_o, exp_code);
      chk("R6 idle", busy_o, 0);
    end

    // R5 collision: completion and clear same edge
    wr(2'd1, ctl(1, 0, 0, 0));
    @(negedge clk_i);
    smp_valid_i = 1'b1; smp_data_i = 9'd511;
    wr_en_i = 1'b1; wr_addr_i = 2'd2; wr_data_i = 9'b001;
    @(negedge clk_i);
    smp_valid_i = 1'b0; wr_en_i = 1'b0;
    exp_code = 511;
    chk("R5 set wins", irq_done_o, 1);
    chk("R4 code 511", vcom_code_o, 511);
    wr(2'd2, 9'b001);
    chk("R5 clear", irq_done_o, 0);

    // R7 fault mid-measurement
    wr(2'd1, ctl(1, 3, 0, 0));
    for (int i = 0; i < 2; i++) begin
      @(negedge clk_i); smp_valid_i = 1'b1; smp_data_i = 9'd10;
    end
    @(negedge clk_i); smp_valid_i = 1'b0; range_fault_i = 1'b1;
    @(negedge clk_i);
    chk("R7 fault flag", irq_fault_o, 1);
    chk("R7 drv off", drv_en_o, 0);
    chk("R7 aborted", busy_o, 0);
    chk("R7 no done", irq_done_o, 0);
    chk("R7 code kept", vcom_code_o, exp_code);
    wr(2'd2, 9'b010);
    chk("R7 set wins", irq_fault_o, 1);
    range_fault_i = 1'b0;
    wr(2'd1, ctl(1, 0, 0, 0));
    chk("R7 acquire blocked", busy_o, 0);
    wr(2'd2, 9'b010);
    chk("R7 cleared", irq_fault_o, 0);
    chk("R7 drv on", drv_en_o, 1);

    // random mix
    for (int it = 0; it < 30; it++) begin
      int op = $urandom_range(0, 2);
      if (op == 0) begin
        int c = $urandom_range(0, 511);
        wr(2'd0, 9'(c)); exp_code = c;
        chk("R2 random write", vcom_code_o, exp_code);
      end else begin
        acquire($urandom_range(0, 3), "rnd");
        wr(2'd2, 9'b001);
      end
    end

    // R8 budget
    for (int i = 0; i < 100; i++) begin
      wr(2'd1, ctl(0, 0, 0, 1));
      chk("R8 pulse", nvm_wr_o, 1);
      chk("R8 data", nvm_data_o, exp_code);
      chk("R8 used", nvm_used_o, i + 1);
    end
    chk("R8 no err yet", irq_nvm_err_o, 0);
    wr(2'd1, ctl(0, 0, 0, 1));
    chk("R8 refused", nvm_wr_o, 0);
    chk("R8 err", irq_nvm_err_o, 1);
    chk("R8 used sat", nvm_used_o, 100);
    wr(2'd2, 9'b100);
    chk("R8 err clear", irq_nvm_err_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule